// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends a message over a frame-based maintenance channel, one byte per handshake. Every frame carries one monitor byte and one active-low transmit flag (here called MX) from this side. The far receiver answers with its own active-low acknowledge flag (here called MR). The transmitter puts a byte on the channel with MX low and repeats it in every frame. It advances only after the byte has been seen for a minimum number of frames and the receiver has pulled MR low. It advances in the frame where that acknowledge edge is seen, so no idle frame is spent between bytes.

The channel is a wired-AND (open-drain) line. Each frame, the block reads back the value the line actually carried. If a bit it sent as 1 came back as 0, another talker is present. The block then releases the line by driving all ones with MX high, raises a sticky collision flag and goes idle. A message comes from a show-ahead FIFO whose entries carry a last-byte marker. After the last byte is acknowledged, MX stays high for a set number of frames to mark the end of the message, and then a sticky done flag rises.

All state changes on the clock edge where `frame_tick` is high. That pulse marks the end of one frame and the start of the next. The line inputs sampled with it describe the frame that just ended. The outputs registered on that edge are held for the whole following frame.

Top module: `mon_tx`

## Requirements
- R1: After reset, `mon_byte` is all ones, `mx_bit` is 1, `tx_done` and `tx_collision` are 0 and `fifo_pop` is 0.
- R2: The block starts a message only at a `frame_tick` in idle where all three hold: the FIFO is non-empty, `line_mx` reads 1 and `rx_busy` is 0. It then pops one entry, and from the next frame drives `mx_bit` = 0 with the FIFO byte on `mon_byte`. If `line_mx` is 0 or `rx_busy` is 1, nothing starts and nothing is popped.
- R3: A byte in progress stays on `mon_byte` with `mx_bit` = 0 in every frame until it is acknowledged. An acknowledge is a falling edge of `rx_mr`: 1 at one `frame_tick` and 0 at the next. MR held low does not acknowledge a new byte.
- R4: A byte occupies at least MIN_REP frames (default 2). A falling edge seen earlier is remembered, and the byte advances at the end of its MIN_REP-th frame.
- R5: Once the minimum is met, the block advances on the same `frame_tick` that shows the falling edge. The next byte appears in the very next frame and `mx_bit` stays 0.
- R6: If a non-last byte is acknowledged while the FIFO is empty, the byte is held with `mx_bit` = 0. It advances at the first `frame_tick` where data is present, with no new edge needed.
- R7: After the last byte (FIFO last marker = 1) is acknowledged, `mx_bit` = 1 and `mon_byte` is all ones for EOM_FRAMES frames (default 2). `tx_done` rises at the end of the last of those frames. No new message starts before that point.
- R8: While sending, if any bit position with 1 on `mon_byte` reads 0 on `line_byte`, the next frame has `mon_byte` all ones, `mx_bit` = 1 and `tx_collision` = 1. The block returns to idle and pops nothing more. A position sent as 0 and read as 0 is not a collision.
- R9: `tx_done` and `tx_collision` stay set until the next message start clears both. They are never set together.
- R10: `mon_byte` and `mx_bit` change only on an edge where `frame_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| fifo_empty | input | 1 | Message FIFO has no entry |
| fifo_data | input | DATA_W | Head byte of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head byte is the last of its message |
| fifo_pop | output | 1 | Removes the FIFO head this cycle |
| rx_mr | input | 1 | Receiver acknowledge seen in the ended frame, active low |
| line_mx | input | 1 | MX value read back from the line, 1 = free |
| line_byte | input | DATA_W | Monitor byte read back from the open-drain line |
| rx_busy | input | 1 | A receive transfer is in progress |
| mon_byte | output | DATA_W | Monitor byte driven for the current frame |
| mx_bit | output | 1 | Transmit flag, active low |
| tx_done | output | 1 | Last message completed with end-of-message frames |
| tx_collision | output | 1 | Last message aborted by a collision |

## Verification
A wrong internal state in this block shows up at the ports within one frame. A lost acknowledge memory or a bad frame counter makes `mon_byte` either hold one frame too long or change one frame too early. A stale MR history makes a held-low MR advance a byte that was never acknowledged. A bad end-of-message counter moves the rise of `tx_done` by a frame. A collision test on the wrong bits either misses a corrupted 1 or aborts on a harmless 0, and `mx_bit` and the FIFO occupancy show this in the frame right after.

// File: rtl/mon_tx_pkg.sv
// Shared types for the monitor channel transmitter.
package mon_tx_pkg;

    // Transmitter phases: free, sending bytes, end-of-message idle frames.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_EOM  = 2'd2
    } mtx_state_t;

endpackage

// File: rtl/mon_collide.sv
// Per-bit collision detector for a wired-AND line.
// Does: flags any bit that was driven 1 but read back 0.
// Assumes: sent and seen belong to the same frame; en gates the check.
module mon_collide #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] sent,
    input  logic [W-1:0] seen,
    output logic         hit
);

    logic [W-1:0] bit_hit;

    // One comparator per bit position: a released 1 pulled low by another talker.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_hit[i] = sent[i] & ~seen[i];
    end

    // Any bit counts, but only while the check is enabled.
    assign hit = en & (|bit_hit);

endmodule

// File: rtl/mon_ack_track.sv
// Acknowledge tracker for one byte in flight.
// Does: watches MR for a 1-to-0 edge across frames, remembers it, counts
// frames the byte has occupied and grants the advance once both hold.
// Assumes: rx_mr is valid when tick is high; clear pulses with tick on a load.
module mon_ack_track #(
    parameter int MIN_REP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic clear,
    input  logic rx_mr,
    output logic ack_ok
);

    localparam int CW = $clog2(MIN_REP + 1);

    logic          mr_prev;
    logic          ack_seen;
    logic [CW-1:0] frames;
    logic          fall;

    // Falling edge of the acknowledge between two consecutive frame samples.
    assign fall = mr_prev & ~rx_mr;

    // Advance allowed when an edge is seen (now or earlier) and the frame minimum is met.
    assign ack_ok = active & tick & (ack_seen | fall) & (frames >= CW'(MIN_REP - 1));

    // MR history, edge memory and frame count for the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_prev  <= 1'b1;
            ack_seen <= 1'b0;
            frames   <= '0;
        end else if (tick) begin
            mr_prev <= rx_mr;
            if (clear || !active) begin
                ack_seen <= 1'b0;
                frames   <= '0;
            end else begin
                if (fall) begin
                    ack_seen <= 1'b1;
                end
                if (frames < CW'(MIN_REP)) begin
                    frames <= frames + 1'b1;
                end
            end
        end
    end

    // A grant never comes from an MR level that was low in both samples without a remembered edge.
    assert_no_level_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active && !ack_seen && !mr_prev) |-> !ack_ok);

endmodule

// File: rtl/mon_frame_timer.sv
// End-of-message frame timer.
// Does: counts frame ticks while run is high and fires on the last one.
// Assumes: run stays high from entry until fire.
module mon_frame_timer #(
    parameter int FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic fire
);

    localparam int TW = $clog2(FRAMES + 1);

    logic [TW-1:0] cnt;

    // Fires on the tick that closes the FRAMES-th idle frame.
    assign fire = run & tick & (cnt == TW'(FRAMES - 1));

    // Frame counter, held at zero outside the end-of-message phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || fire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The timer can only fire after it has been running for at least a cycle.
    assert_timer_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(run));

endmodule

// File: rtl/mon_tx.sv
// Monitor channel transmitter, top level.
// Does: starts a message when the line is free, repeats each byte with MX
// low until acknowledged, advances on the acknowledge edge, marks the end
// of the message with idle frames, and aborts on a per-bit collision.
// Assumes: show-ahead FIFO; all line inputs describe the frame that ends
// with frame_tick; half-duplex use only (rx_busy blocks a start).
module mon_tx
    import mon_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_REP    = 2,
    parameter int EOM_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              rx_mr,
    input  logic              line_mx,
    input  logic [DATA_W-1:0] line_byte,
    input  logic              rx_busy,
    output logic [DATA_W-1:0] mon_byte,
    output logic              mx_bit,
    output logic              tx_done,
    output logic              tx_collision
);

    mtx_state_t        st;
    logic [DATA_W-1:0] mon_q;
    logic              mx_q;
    logic              last_q;
    logic              done_q;
    logic              coll_q;

    logic sending;
    logic coll_hit;
    logic ack_ok;
    logic eom_fire;
    logic can_start;
    logic adv;
    logic finish;
    logic load;

    assign sending = (st == ST_SEND);

    // Collision check on the byte this block put on the line last frame.
    mon_collide #(.W(DATA_W)) u_collide (
        .en   (sending),
        .sent (mon_q),
        .seen (line_byte),
        .hit  (coll_hit)
    );

    // Acknowledge edge memory and minimum repeat count.
    mon_ack_track #(.MIN_REP(MIN_REP)) u_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (frame_tick),
        .active (sending),
        .clear  (load),
        .rx_mr  (rx_mr),
        .ack_ok (ack_ok)
    );

    // End-of-message idle frame counter.
    mon_frame_timer #(.FRAMES(EOM_FRAMES)) u_eom (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (frame_tick),
        .run  (st == ST_EOM),
        .fire (eom_fire)
    );

    // Decisions for this frame boundary.
    always_comb begin
        can_start = (st == ST_IDLE) && !fifo_empty && line_mx && !rx_busy;
        adv       = sending && !coll_hit && ack_ok && !last_q && !fifo_empty;
        finish    = sending && !coll_hit && ack_ok && last_q;
        load      = (frame_tick && can_start) || adv;
    end

    assign fifo_pop     = load;
    assign mon_byte     = mon_q;
    assign mx_bit       = mx_q;
    assign tx_done      = done_q;
    assign tx_collision = coll_q;

    // Phase sequencing and output registers, updated only on frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            mon_q  <= '1;
            mx_q   <= 1'b1;
            last_q <= 1'b0;
            done_q <= 1'b0;
            coll_q <= 1'b0;
        end else if (frame_tick) begin
            case (st)
                ST_IDLE: begin
                    if (can_start) begin
                        st     <= ST_SEND;
                        mon_q  <= fifo_data;
                        last_q <= fifo_last;
                        mx_q   <= 1'b0;
                        done_q <= 1'b0;
                        coll_q <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (coll_hit) begin
                        st     <= ST_IDLE;
                        mon_q  <= '1;
                        mx_q   <= 1'b1;
                        coll_q <= 1'b1;
                    end else if (finish) begin
                        st    <= ST_EOM;
                        mon_q <= '1;
                        mx_q  <= 1'b1;
                    end else if (adv) begin
                        mon_q  <= fifo_data;
                        last_q <= fifo_last;
                    end
                end
                ST_EOM: begin
                    if (eom_fire) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs hold between frame boundaries.
    assert_quiet_between_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(mon_byte) && $stable(mx_bit)));

    // A pop only happens on a boundary with data present.
    assert_pop_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (frame_tick && !fifo_empty));

    // A busy line or an active receive keeps the channel released.
    assert_blocked_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && st == ST_IDLE && (rx_busy || !line_mx)) |=> mx_bit);

    // A granted, non-final acknowledge with data waiting moves to the next byte.
    assert_advance_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && sending && !coll_hit && !last_q && !fifo_empty) |-> fifo_pop);

    // A collision releases the line and raises the flag in the next frame.
    assert_collision_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && coll_hit) |=> (mx_bit && mon_byte == '1 && tx_collision));

    // End-of-message frames keep the line released.
    assert_eom_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EOM) |-> (mx_bit && mon_byte == '1));

    // The two outcome flags exclude each other.
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_collision));

endmodule

// File: tb/sim_mon_tx.sv
`timescale 1ns/1ps
// Bench for mon_tx: directed corner cases, then random messages against a
// bench-side receiver that acknowledges after a random number of frames.
module sim_mon_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_last = 1'b0;
    logic       fifo_pop;
    logic       rx_mr = 1'b1;
    logic       line_mx = 1'b1;
    logic [7:0] line_byte = 8'hFF;
    logic       rx_busy = 1'b0;
    logic [7:0] mon_byte;
    logic       mx_bit;
    logic       tx_done;
    logic       tx_collision;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] q[$];

    always #2.5 clk = ~clk;

    mon_tx u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_pop(fifo_pop), .rx_mr(rx_mr), .line_mx(line_mx),
        .line_byte(line_byte), .rx_busy(rx_busy), .mon_byte(mon_byte),
        .mx_bit(mx_bit), .tx_done(tx_done), .tx_collision(tx_collision)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic refresh();
        fifo_empty = (q.size() == 0);
        fifo_data  = fifo_empty ? 8'h00 : q[0][7:0];
        fifo_last  = fifo_empty ? 1'b0 : q[0][8];
    endtask

    task automatic push(input logic [7:0] d, input logic last);
        q.push_back({last, d});
        refresh();
    endtask

    // One frame: present the line state of the ending frame, pulse the boundary.
    task automatic frame(input logic mr, input logic lmx, input logic [7:0] mask, input logic busy);
        logic popped;
        @(negedge clk);
        rx_mr = mr;
        line_mx = lmx;
        line_byte = mon_byte & mask;
        rx_busy = busy;
        frame_tick = 1'b1;
        #1;
        popped = fifo_pop;
        @(posedge clk);
        #1;
        frame_tick = 1'b0;
        if (popped) begin
            void'(q.pop_front());
            refresh();
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [7:0] b, input logic mx);
        chk(mon_byte == b, req, {24'h0, mon_byte}, {24'h0, b});
        chk(mx_bit == mx, req, {31'h0, mx_bit}, {31'h0, mx});
    endtask

    // Expected receiver wait for a byte: 1 to 3 high frames before the edge.
    function automatic int pick_wait();
        return 1 + int'($urandom % 3);
    endfunction

    initial begin : watchdog
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1c0ffee5));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_out("R1", 8'hFF, 1'b1);
        chk(tx_done == 0 && tx_collision == 0, "R1", {30'h0, tx_done, tx_collision}, 0);
        chk(fifo_pop == 0, "R1", {31'h0, fifo_pop}, 0);

        push(8'hA5, 1'b0);
        push(8'h3C, 1'b0);
        // R2: line MX held low by another device blocks the start
        frame(1, 0, 8'hFF, 0);
        expect_out("R2", 8'hFF, 1'b1);
        chk(q.size() == 2, "R2", q.size(), 2);
        // R2: an active receive blocks the start
        frame(1, 1, 8'hFF, 1);
        expect_out("R2", 8'hFF, 1'b1);
        chk(q.size() == 2, "R2", q.size(), 2);
        // R2: free line starts the message
        frame(1, 1, 8'hFF, 0);
        expect_out("R2", 8'hA5, 1'b0);
        chk(q.size() == 1, "R2", q.size(), 1);
        // R4: edge in the first frame only is remembered, byte held
        frame(0, 1, 8'hFF, 0);
        expect_out("R4", 8'hA5, 1'b0);
        // R4: advance at the end of the second frame without a new edge
        frame(0, 1, 8'hFF, 0);
        expect_out("R4", 8'h3C, 1'b0);
        // R3: MR held low gives no acknowledge for the new byte
        frame(0, 1, 8'hFF, 0);
        expect_out("R3", 8'h3C, 1'b0);
        frame(0, 1, 8'hFF, 0);
        expect_out("R3", 8'h3C, 1'b0);
        frame(1, 1, 8'hFF, 0);
        expect_out("R3", 8'h3C, 1'b0);
        // R6: acknowledged with the FIFO empty, byte held with MX low
        frame(0, 1, 8'hFF, 0);
        expect_out("R6", 8'h3C, 1'b0);
        push(8'hC3, 1'b1);
        // R6: data arrives, remembered acknowledge advances
        frame(0, 1, 8'hFF, 0);
        expect_out("R6", 8'hC3, 1'b0);
        // R5: fresh edge after the minimum, advance on that boundary
        frame(1, 1, 8'hFF, 0);
        expect_out("R5", 8'hC3, 1'b0);
        frame(0, 1, 8'hFF, 0);
        // R7: last byte done, line released
        expect_out("R7", 8'hFF, 1'b1);
        chk(tx_done == 0, "R7", {31'h0, tx_done}, 0);
        push(8'h11, 1'b1);
        frame(1, 1, 8'hFF, 0);
        expect_out("R7", 8'hFF, 1'b1);
        chk(tx_done == 0, "R7", {31'h0, tx_done}, 0);
        chk(q.size() == 1, "R7", q.size(), 1);
        frame(1, 1, 8'hFF, 0);
        expect_out("R7", 8'hFF, 1'b1);
        chk(tx_done == 1, "R7", {31'h0, tx_done}, 1);
        // R9: next start clears done
        frame(1, 1, 8'hFF, 0);
        expect_out("R9", 8'h11, 1'b0);
        chk(tx_done == 0, "R9", {31'h0, tx_done}, 0);
        // R8: zeros read where zeros were sent is not a collision
        frame(1, 1, 8'h11, 0);
        expect_out("R8", 8'h11, 1'b0);
        chk(tx_collision == 0, "R8", {31'h0, tx_collision}, 0);
        push(8'h77, 1'b0);
        // R8: a driven 1 read as 0 aborts the message
        frame(1, 1, 8'hEF, 0);
        expect_out("R8", 8'hFF, 1'b1);
        chk(tx_collision == 1, "R8", {31'h0, tx_collision}, 1);
        chk(q.size() == 1, "R8", q.size(), 1);
        // R9: collision flag stays while idle
        frame(1, 0, 8'hFF, 0);
        chk(tx_collision == 1, "R9", {31'h0, tx_collision}, 1);
        frame(1, 1, 8'hFF, 0);
        expect_out("R9", 8'h77, 1'b0);
        chk(tx_collision == 0, "R9", {31'h0, tx_collision}, 0);
        frame(1, 1, 8'h00, 0);
        expect_out("R8", 8'hFF, 1'b1);
        chk(tx_collision == 1 && tx_done == 0, "R9", {30'h0, tx_done, tx_collision}, 1);

        // Random messages against a bench receiver (R3, R5, R7)
        for (int m = 0; m < 12; m++) begin
            int len = 1 + int'($urandom % 5);
            logic [7:0] msg[5];
            for (int i = 0; i < len; i++) begin
                msg[i] = 8'($urandom);
                push(msg[i], (i == len - 1));
            end
            frame(1, 1, 8'hFF, 0);
            for (int i = 0; i < len; i++) begin
                int w = pick_wait();
                for (int k = 0; k < w; k++) begin
                    expect_out("R3", msg[i], 1'b0);
                    frame(1, 1, 8'hFF, 0);
                end
                expect_out("R5", msg[i], 1'b0);
                frame(0, 1, 8'hFF, 0);
            end
            expect_out("R7", 8'hFF, 1'b1);
            frame(1, 1, 8'hFF, 0);
            chk(tx_done == 0, "R7", {31'h0, tx_done}, 0);
            frame(1, 1, 8'hFF, 0);
            chk(tx_done == 1, "R7", {31'h0, tx_done}, 1);
            chk(q.size() == 0, "R7", q.size(), 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule